// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers interrupt requests from eight peripheral sources and presents them to a CPU as a single request together with a vector number. Software reaches it over an 8-bit I/O port bus. Through that bus it programs a vector base and an enable mask, reads the pending bits, and clears pending bits by writing ones to an acknowledge port. Each peripheral drives a raise strobe that latches its pending bit and a lower strobe that clears it.

The CPU marks each instruction boundary with a strobe. If the instruction just retired must shield the next boundary from interrupts, the CPU also drives an inhibit flag with that strobe. Such instructions are a prefix byte, a stack-segment load, a flags pop, an interrupt return and a set of the interrupt flag. At an uninhibited boundary with an enabled source pending, the controller raises a wake pulse that releases a halted core, whatever the CPU interrupt flag says. The registered request is raised only if that flag is set, and it is held until the CPU accepts it. At the accept the controller captures the vector of the highest-priority source then pending. The CPU then fetches the handler from table entry vector*4, offset word first and segment word at +2.

A mode input selects how the base register is masked. In monochrome mode the base is aligned to eight vectors. In colour mode it is aligned to two.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset the base, enable and status registers read 0, and irq_req, wake and irq_vector are 0.
- R2: A read at address 0xB2 returns the enable mask and a read at 0xB4 returns the status. Any address other than 0xB0, 0xB2 and 0xB4 reads as 0, and that includes the acknowledge port 0xB6.
- R3: With mono_mode=1, a write to 0xB0 stores only data bits 7..3. A read of 0xB0 in that mode returns the stored value OR 0x03.
- R4: With mono_mode=0, a write to 0xB0 stores the data with bit 0 cleared. A read returns the stored value unchanged.
- R5: raise_i[n] sets status bit n and lower_i[n] clears it, one cycle later. If both hit the same bit in the same cycle, raise wins. The bit assignment is fixed: 0 serial transmit, 1 input, 2 cartridge, 3 serial receive, 4 line compare, 5 vblank timer, 6 vblank, 7 hblank timer.
- R6: A write to 0xB6 clears every status bit that is 1 in the data byte. A raise of the same bit in the same cycle wins over that clear.
- R7: When boundary=1, poll_block=0 and (status AND enable) is nonzero, wake is 1 in that same cycle, even with cpu_if=0.
- R8: irq_req becomes 1 in the cycle after a boundary that asserts wake, but only if cpu_if=1 at that boundary. It then stays 1 until irq_ack.
- R9: A boundary with poll_block=1 asserts neither wake nor a new request.
- R10: In the cycle after irq_ack, irq_req is 0 and irq_vector equals base + n, where n is the highest set bit of (status AND enable) at the accept. Bit 7 has the highest priority.
- R11: Sources whose enable bit is 0 never cause wake or a request, while their status bit stays readable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mono_mode | input | 1 | 1 = monochrome base masking, 0 = colour |
| io_wr | input | 1 | Port write strobe |
| io_addr | input | 8 | Port address |
| io_wdata | input | 8 | Port write data |
| io_rdata | output | 8 | Port read data (combinational from address) |
| raise_i | input | 8 | Per-source set strobes |
| lower_i | input | 8 | Per-source clear strobes |
| boundary | input | 1 | Instruction boundary strobe from the CPU |
| poll_block | input | 1 | Inhibit polling at this boundary |
| cpu_if | input | 1 | CPU interrupt-enable flag |
| irq_ack | input | 1 | CPU accepts the request |
| wake | output | 1 | Release halt |
| irq_req | output | 1 | Registered interrupt request |
| irq_vector | output | 8 | Vector captured at accept |

## Verification
The assertions take it as given that mono_mode does not change between a base write and the cycle after it. They also assume irq_ack is a one-cycle strobe that arrives only while a request is outstanding. Both the raise-wins checks and the acknowledge check assume raise, lower and acknowledge strobes are single-cycle pulses. The stimulus changes the mode only while the bus is idle and pulses every strobe for exactly one cycle. It issues an accept only after the bench's own model has predicted a request.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned SRC_N   = 8;
  localparam logic [7:0] A_BASE   = 8'hB0;
  localparam logic [7:0] A_ENABLE = 8'hB2;
  localparam logic [7:0] A_STATUS = 8'hB4;
  localparam logic [7:0] A_CLEAR  = 8'hB6;
endpackage

// File: rtl/ivc_regs.sv
module ivc_regs
  import ivc_pkg::*;
#(
  parameter int unsigned DW   = DATA_W,
  parameter int unsigned NSRC = SRC_N
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mono_mode,
  input  logic            io_wr,
  input  logic [7:0]      io_addr,
  input  logic [DW-1:0]   io_wdata,
  input  logic [NSRC-1:0] raise_i,
  input  logic [NSRC-1:0] lower_i,
  output logic [DW-1:0]   base_q,
  output logic [NSRC-1:0] enable_q,
  output logic [NSRC-1:0] status_q,
  output logic [DW-1:0]   io_rdata
);
  localparam logic [DW-1:0] MONO_KEEP = {{(DW-3){1'b1}}, 3'b000};
  localparam logic [DW-1:0] COL_KEEP  = {{(DW-1){1'b1}}, 1'b0};
  localparam logic [DW-1:0] MONO_OR   = DW'(3);

  logic            base_we, en_we, clr_we;
  logic [DW-1:0]   base_d;
  logic [NSRC-1:0] clr_mask, status_d;

  always_comb begin
    base_we  = io_wr && (io_addr == A_BASE);
    en_we    = io_wr && (io_addr == A_ENABLE);
    clr_we   = io_wr && (io_addr == A_CLEAR);
    base_d   = io_wdata & (mono_mode ? MONO_KEEP : COL_KEEP);
    clr_mask = clr_we ? io_wdata[NSRC-1:0] : '0;
    status_d = (status_q & ~clr_mask & ~lower_i) | raise_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q   <= '0;
      enable_q <= '0;
      status_q <= '0;
    end else begin
      if (base_we) base_q <= base_d;
      if (en_we)   enable_q <= io_wdata[NSRC-1:0];
      status_q <= status_d;
    end
  end

  always_comb begin
    unique case (io_addr)
      A_BASE:   io_rdata = mono_mode ? (base_q | MONO_OR) : base_q;
      A_ENABLE: io_rdata = DW'(enable_q);
      A_STATUS: io_rdata = DW'(status_q);
      default:  io_rdata = '0;
    endcase
  end

  p_raise_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|raise_i) |=> ((status_q & $past(raise_i)) == $past(raise_i)));
  p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((status_q & $past(clr_mask) & ~$past(raise_i)) == '0));
  p_mono_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (base_we && mono_mode) |=> (base_q[2:0] == 3'b000));
  p_col_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (base_we && !mono_mode) |=> (base_q[0] == 1'b0));
endmodule

// File: rtl/ivc_prio.sv
module ivc_prio #(
  parameter int unsigned NSRC = 8,
  localparam int unsigned IDXW = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] pend,
  output logic            any,
  output logic [IDXW-1:0] idx
);
  logic [NSRC-1:0] grant;

  for (genvar n = 0; n < NSRC; n++) begin : g_grant
    if (n == NSRC-1) begin : g_top
      assign grant[n] = pend[n];
    end else begin : g_low
      assign grant[n] = pend[n] & ~(|pend[NSRC-1:n+1]);
    end
  end

  always_comb begin
    idx = '0;
    for (int n = 0; n < NSRC; n++)
      if (grant[n]) idx = IDXW'(n);
  end

  assign any = |pend;

  p_one_grant_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  p_idx_pending_r10: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> pend[idx]);
endmodule

// File: rtl/ivc_gate.sv
module ivc_gate #(
  parameter int unsigned DW   = 8,
  parameter int unsigned IDXW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pend_any,
  input  logic [IDXW-1:0] idx,
  input  logic [DW-1:0]   base_q,
  input  logic            boundary,
  input  logic            poll_block,
  input  logic            cpu_if,
  input  logic            irq_ack,
  output logic            wake,
  output logic            irq_req,
  output logic [DW-1:0]   irq_vector
);
  logic          poll_ok, req_d;
  logic [DW-1:0] vec_d;

  always_comb begin
    poll_ok = boundary && !poll_block;
    wake    = poll_ok && pend_any;
    if (irq_ack)             req_d = 1'b0;
    else if (wake && cpu_if) req_d = 1'b1;
    else                     req_d = irq_req;
    vec_d = base_q + DW'(idx);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_req    <= 1'b0;
      irq_vector <= '0;
    end else begin
      irq_req <= req_d;
      if (irq_ack) irq_vector <= vec_d;
    end
  end

  p_accept_drops_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !irq_req);
  p_req_needs_if_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> $past(cpu_if && boundary && !poll_block));
  p_block_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && poll_block && !irq_req) |=> !irq_req);
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import ivc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mono_mode,
  input  logic        io_wr,
  input  logic [7:0]  io_addr,
  input  logic [7:0]  io_wdata,
  output logic [7:0]  io_rdata,
  input  logic [7:0]  raise_i,
  input  logic [7:0]  lower_i,
  input  logic        boundary,
  input  logic        poll_block,
  input  logic        cpu_if,
  input  logic        irq_ack,
  output logic        wake,
  output logic        irq_req,
  output logic [7:0]  irq_vector
);
  localparam int unsigned IDXW = $clog2(SRC_N);

  logic [1:0]        rst_sync;
  logic              rst_int_n;
  logic [DATA_W-1:0] base_q;
  logic [SRC_N-1:0]  enable_q, status_q, pend;
  logic              pend_any;
  logic [IDXW-1:0]   idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  ivc_regs #(.DW(DATA_W), .NSRC(SRC_N)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .mono_mode(mono_mode),
    .io_wr(io_wr), .io_addr(io_addr), .io_wdata(io_wdata),
    .raise_i(raise_i), .lower_i(lower_i),
    .base_q(base_q), .enable_q(enable_q), .status_q(status_q),
    .io_rdata(io_rdata)
  );

  assign pend = status_q & enable_q;

  ivc_prio #(.NSRC(SRC_N)) u_prio (
    .clk(clk), .rst_n(rst_int_n), .pend(pend), .any(pend_any), .idx(idx)
  );

  ivc_gate #(.DW(DATA_W), .IDXW(IDXW)) u_gate (
    .clk(clk), .rst_n(rst_int_n), .pend_any(pend_any), .idx(idx),
    .base_q(base_q), .boundary(boundary), .poll_block(poll_block),
    .cpu_if(cpu_if), .irq_ack(irq_ack), .wake(wake),
    .irq_req(irq_req), .irq_vector(irq_vector)
  );
endmodule

// File: tb/irq_vector_ctrl_tb.sv
`timescale 1ns/1ps
module irq_vector_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mono_mode = 1'b0, io_wr = 1'b0;
  logic [7:0] io_addr = 8'h00, io_wdata = 8'h00;
  logic [7:0] raise_i = 8'h00, lower_i = 8'h00;
  logic       boundary = 1'b0, poll_block = 1'b0, cpu_if = 1'b0, irq_ack = 1'b0;
  logic [7:0] io_rdata, irq_vector;
  logic       wake, irq_req;
  int total = 0, fails = 0;

  always #2.5 clk = ~clk;

  irq_vector_ctrl u_dut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); io_wr = 1'b1; io_addr = a; io_wdata = d;
    @(negedge clk); io_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk); io_addr = a; #1 v = io_rdata;
  endtask

  task automatic strobe(input logic [7:0] r, input logic [7:0] l);
    @(negedge clk); raise_i = r; lower_i = l;
    @(negedge clk); raise_i = 8'h00; lower_i = 8'h00;
  endtask

  task automatic poll(input logic cif, input logic blk, output logic w);
    @(negedge clk); boundary = 1'b1; cpu_if = cif; poll_block = blk; #1 w = wake;
    @(negedge clk); boundary = 1'b0; poll_block = 1'b0;
  endtask

  task automatic accept();
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
  endtask

  function automatic int top_bit(input logic [7:0] m);
    for (int n = 7; n >= 0; n--) if (m[n]) return n;
    return 0;
  endfunction

  initial begin
    #(5.0 * 150000);
    check(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [7:0] v, e, p;
    logic w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(8'hB0, v); check(v == 8'h00, "R1 base", v, 0);
    rd(8'hB2, v); check(v == 8'h00, "R1 enable", v, 0);
    rd(8'hB4, v); check(v == 8'h00, "R1 status", v, 0);
    check(!irq_req && !wake && irq_vector == 8'h00, "R1 outputs", irq_req, 0);

    // R3 / R4 base masking
    mono_mode = 1'b1; wr(8'hB0, 8'hFF);
    rd(8'hB0, v); check(v == 8'hFB, "R3 mono base", v, 8'hFB);
    wr(8'hB0, 8'h0C);
    rd(8'hB0, v); check(v == 8'h0B, "R3 mono base low", v, 8'h0B);
    mono_mode = 1'b0; wr(8'hB0, 8'hFF);
    rd(8'hB0, v); check(v == 8'hFE, "R4 colour base", v, 8'hFE);

    // R2 decode
    wr(8'hB2, 8'hA5);
    rd(8'hB2, v); check(v == 8'hA5, "R2 enable read", v, 8'hA5);
    strobe(8'h3C, 8'h00);
    rd(8'hB6, v); check(v == 8'h00, "R2 ack port reads 0", v, 0);
    rd(8'h00, v); check(v == 8'h00, "R2 unmapped", v, 0);
    rd(8'hB4, v); check(v == 8'h3C, "R2 status read", v, 8'h3C);

    // R5 lower, raise-over-lower
    strobe(8'h00, 8'h0C);
    rd(8'hB4, v); check(v == 8'h30, "R5 lower clears", v, 8'h30);
    strobe(8'h01, 8'h01);
    rd(8'hB4, v); check(v == 8'h31, "R5 raise beats lower", v, 8'h31);

    // R6 ack, raise beats ack
    @(negedge clk); io_wr = 1'b1; io_addr = 8'hB6; io_wdata = 8'h11; raise_i = 8'h10;
    @(negedge clk); io_wr = 1'b0; raise_i = 8'h00;
    rd(8'hB4, v); check(v == 8'h30, "R6 raise beats ack", v, 8'h30);
    wr(8'hB6, 8'hFF);
    rd(8'hB4, v); check(v == 8'h00, "R6 ack all", v, 0);

    // R11 disabled source, R7 wake with if clear, R9 block
    wr(8'hB2, 8'h00); strobe(8'h40, 8'h00);
    poll(1'b1, 1'b0, w);
    check(!w, "R11 no wake when disabled", w, 0);
    check(!irq_req, "R11 no request when disabled", irq_req, 0);
    rd(8'hB4, v); check(v == 8'h40, "R11 status visible", v, 8'h40);
    wr(8'hB2, 8'h40);
    poll(1'b1, 1'b1, w);
    check(!w && !irq_req, "R9 blocked boundary", {w, irq_req}, 0);
    poll(1'b0, 1'b0, w);
    check(w, "R7 wake with if clear", w, 1);
    check(!irq_req, "R8 no request with if clear", irq_req, 0);
    poll(1'b1, 1'b0, w);
    check(irq_req, "R8 request", irq_req, 1);
    repeat (3) @(negedge clk);
    check(irq_req, "R8 request held", irq_req, 1);
    accept();
    check(!irq_req, "R10 accept drops", irq_req, 0);
    check(irq_vector == 8'hFE + 8'd6, "R10 vector", irq_vector, 8'hFE + 8'd6);

    // Sweep: all status patterns against several masks
    wr(8'hB0, 8'h40);
    for (int pi = 0; pi < 256; pi++) begin
      for (int k = 0; k < 3; k++) begin
        p = 8'(pi);
        e = (k == 0) ? 8'hFF : (k == 1) ? 8'h5A : (p ^ 8'h33);
        wr(8'hB6, 8'hFF);
        strobe(p, 8'h00);
        wr(8'hB2, e);
        rd(8'hB4, v); check(v == p, "R5 sweep status", v, p);
        poll(1'b1, 1'b0, w);
        check(w == ((p & e) != 0), "R7 sweep wake", w, (p & e) != 0);
        check(irq_req == ((p & e) != 0), "R8 sweep request", irq_req, (p & e) != 0);
        if ((p & e) != 0) begin
          accept();
          check(irq_vector == 8'(8'h40 + top_bit(p & e)), "R10 sweep vector",
                irq_vector, 8'h40 + top_bit(p & e));
          check(!irq_req, "R10 sweep drop", irq_req, 0);
        end
      end
    end

    // Mono base vectors
    mono_mode = 1'b1; wr(8'hB0, 8'h88); mono_mode = 1'b0;
    for (int n = 0; n < 8; n++) begin
      wr(8'hB6, 8'hFF); wr(8'hB2, 8'hFF);
      strobe(8'(1 << n), 8'h00);
      poll(1'b1, 1'b0, w);
      accept();
      check(irq_vector == 8'(8'h88 + n), "R10 mono vector", irq_vector, 8'h88 + n);
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule